// File: doc/BRIEF.md
# USB Endpoint Buffer-Descriptor Engine

This block is the serial-engine side of one USB endpoint. The endpoint's four-byte descriptor and its data buffer live in a small byte RAM. A CPU write port and the engine both reach that RAM. One status bit decides who may use the descriptor. While the CPU holds it, the status byte carries control options. Once the engine has finished a transaction, it returns the descriptor with the token PID and the final byte count filled in.

A token from the packet layer starts the engine. The engine first looks at ownership and the stall option. It then does one of three things: it answers with a handshake, it streams the buffer out as an IN data packet, or it stores an OUT data packet into the buffer. Afterwards it writes the count byte first and the status byte second, so ownership always comes back last. A control input per endpoint enables each direction and can suppress handshakes for isochronous traffic.

Top module: `usb_bd_engine`

## Requirements
- R1: After reset, `hs_valid`, `tx_valid` and `tx_eop` are low and every RAM byte reads 0 on `cpu_rdata`.
- R2: The descriptor occupies RAM bytes BD_BASE to BD_BASE+3.
  - Byte 0 is the status byte.
  - Byte 1 holds count bits 7:0.
  - Bytes 2 and 3 hold the buffer address, low byte then high byte.
  - The count is 10 bits wide; its bits 9:8 are status bits 1:0.
  - The buffer index is the 16-bit address modulo RAM_DEPTH.
- R3: A token arriving while status bit 7 is 0 (the CPU owns the descriptor) is answered with NAK (`hs_code`=1), and the RAM is left unchanged.
- R4: A token arriving while status bit 7 is 1 and status bit 2 (stall) is 1 is answered with STALL (`hs_code`=2), and the RAM is left unchanged.
- R5: An IN token sends exactly `count` bytes on `tx_valid`/`tx_data`, taken from ascending buffer addresses. It then pulses `tx_eop` with `tx_pid` equal to DATA0 (4'b0011) when status bit 6 is 0, or DATA1 (4'b1011) when status bit 6 is 1.
- R6: An OUT packet is stored from the buffer start, up to `count` bytes; any further bytes are dropped. The count is rewritten as the number of bytes actually stored, and the engine answers ACK (`hs_code`=0) one cycle after `rx_end`.
- R7: On completion with status bit 5 clear, the status byte becomes {2'b00, PID, count[9:8]}, with PID = 4'b1001 for IN and 4'b0001 for OUT. This releases the descriptor to the CPU.
- R8: With status bit 5 (keep) set, completion rewrites only the count, in byte 1 and in status bits 1:0. Status bits 7:2 keep their values, so the engine still owns the descriptor.
- R9: With status bit 3 (toggle sync) set, an OUT packet whose `rx_pid` differs from the expected one is still ACKed, but the descriptor bytes are unchanged. The expected PID is DATA1 when status bit 6 is 1 and DATA0 otherwise. Bytes already received remain in the buffer.
- R10: With status bit 4 (no increment) set, every byte of a transfer uses the buffer start address.
- R11: A token whose direction is disabled is ignored: no handshake, no data, no RAM change. `ep_en_in` enables IN and `ep_en_out` enables OUT.
- R12: While `ep_no_hs` is 1, no handshake is ever issued. Transactions otherwise behave as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | AW | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | RAM byte at `cpu_addr` (combinational) |
| ep_en_in | input | 1 | Enable IN tokens |
| ep_en_out | input | 1 | Enable OUT tokens |
| ep_no_hs | input | 1 | Suppress all handshakes (isochronous) |
| tok_valid | input | 1 | Token strobe for this endpoint |
| tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| rx_valid | input | 1 | OUT data byte valid |
| rx_data | input | 8 | OUT data byte |
| rx_end | input | 1 | End of OUT data packet |
| rx_pid | input | 4 | PID of the OUT data packet, valid with `rx_end` |
| tx_valid | output | 1 | IN data byte valid |
| tx_data | output | 8 | IN data byte |
| tx_eop | output | 1 | End of IN data packet |
| tx_pid | output | 4 | Data PID for the IN packet, valid with `tx_eop` |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 = ACK, 1 = NAK, 2 = STALL |

## Verification
A wrong ownership or stall decision shows up one cycle after the token as a wrong or missing handshake. A wrong buffer pointer or wrong increment decision corrupts the IN byte stream on the very next byte. A wrong receive counter, or a wrong keep or toggle decision, stays hidden until writeback two cycles after the packet ends. It then appears in the descriptor bytes, which the bench reads back through the CPU port and compares with its own memory model after every transaction.

// File: rtl/usb_bd_pkg.sv
`timescale 1ns/1ps
package usb_bd_pkg;
   localparam int CNT_W = 10;

   typedef enum logic [2:0] {
      ST_IDLE, ST_TX, ST_RX, ST_WBC, ST_WBS
   } eng_state_t;

   localparam logic [1:0] HS_ACK   = 2'd0;
   localparam logic [1:0] HS_NAK   = 2'd1;
   localparam logic [1:0] HS_STALL = 2'd2;

   localparam logic [3:0] PID_OUT   = 4'b0001;
   localparam logic [3:0] PID_IN    = 4'b1001;
   localparam logic [3:0] PID_DATA0 = 4'b0011;
   localparam logic [3:0] PID_DATA1 = 4'b1011;

   // status byte bit positions (CPU-owned meaning)
   localparam int SB_OWN    = 7;
   localparam int SB_TOGGLE = 6;
   localparam int SB_KEEP   = 5;
   localparam int SB_NOINC  = 4;
   localparam int SB_SYNC   = 3;
   localparam int SB_STALL  = 2;
endpackage

// File: rtl/usb_bd_ram.sv
`timescale 1ns/1ps
module usb_bd_ram #(
   parameter int DEPTH       = 64,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int AW         = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_we,
   input  logic [AW-1:0]         cpu_addr,
   input  logic [7:0]            cpu_wdata,
   input  logic                  eng_we,
   input  logic [AW-1:0]         eng_addr,
   input  logic [7:0]            eng_wdata,
   output logic [DEPTH-1:0][7:0] q
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      logic       hit_eng, hit_cpu;
      logic [7:0] nxt;
      assign hit_eng = eng_we && (eng_addr == AW'(i));
      assign hit_cpu = cpu_we && (cpu_addr == AW'(i));
      // engine port wins a same-address collision
      assign nxt = hit_eng ? eng_wdata : cpu_wdata;

      if (RESET_CLEAR) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q[i] <= '0;
            else if (hit_eng || hit_cpu) q[i] <= nxt;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_eng || hit_cpu) q[i] <= nxt;
         end
      end
   end
endmodule

// File: rtl/usb_bd_sie_fsm.sv
`timescale 1ns/1ps
module usb_bd_sie_fsm
   import usb_bd_pkg::*;
#(
   parameter int AW      = 6,
   parameter int BD_BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tok_valid,
   input  logic          tok_in,
   input  logic          en_in,
   input  logic          en_out,
   input  logic          no_hs,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_end,
   input  logic [3:0]    rx_pid,
   input  logic [7:0]    stat_i,
   input  logic [7:0]    cntl_i,
   input  logic [7:0]    adrl_i,
   input  logic [7:0]    adrh_i,
   input  logic [7:0]    rd_data_i,
   output logic [AW-1:0] rd_idx_o,
   output logic          we_o,
   output logic [AW-1:0] wa_o,
   output logic [7:0]    wd_o,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_eop,
   output logic [3:0]    tx_pid,
   output logic          hs_valid,
   output logic [1:0]    hs_code
);
   eng_state_t       st_q;
   logic [AW-1:0]    ptr_q;
   logic [CNT_W-1:0] cnt_q, idx_q;
   logic             dir_in_q, keep_q, noinc_q, sync_q, tog_q;
   logic             hs_valid_q;
   logic [1:0]       hs_code_q;

   logic             dir_en, more, rx_take, pid_bad;
   logic [CNT_W-1:0] fin_cnt;
   logic [15:0]      buf_addr;
   logic [3:0]       exp_pid;

   assign dir_en   = tok_in ? en_in : en_out;
   assign buf_addr = {adrh_i, adrl_i};
   assign more     = (idx_q != cnt_q);
   assign rx_take  = (st_q == ST_RX) && !rx_end && rx_valid && more;
   assign exp_pid  = tog_q ? PID_DATA1 : PID_DATA0;
   assign pid_bad  = sync_q && (rx_pid != exp_pid);
   assign fin_cnt  = dir_in_q ? cnt_q : idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         ptr_q      <= '0;
         cnt_q      <= '0;
         idx_q      <= '0;
         dir_in_q   <= 1'b0;
         keep_q     <= 1'b0;
         noinc_q    <= 1'b0;
         sync_q     <= 1'b0;
         tog_q      <= 1'b0;
         hs_valid_q <= 1'b0;
         hs_code_q  <= HS_ACK;
      end else begin
         hs_valid_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (tok_valid && dir_en) begin
               if (!stat_i[SB_OWN]) begin
                  hs_valid_q <= !no_hs;
                  hs_code_q  <= HS_NAK;
               end else if (stat_i[SB_STALL]) begin
                  hs_valid_q <= !no_hs;
                  hs_code_q  <= HS_STALL;
               end else begin
                  st_q     <= tok_in ? ST_TX : ST_RX;
                  dir_in_q <= tok_in;
                  ptr_q    <= buf_addr[AW-1:0];
                  cnt_q    <= {stat_i[1:0], cntl_i};
                  idx_q    <= '0;
                  keep_q   <= stat_i[SB_KEEP];
                  noinc_q  <= stat_i[SB_NOINC];
                  sync_q   <= stat_i[SB_SYNC];
                  tog_q    <= stat_i[SB_TOGGLE];
               end
            end
            ST_TX: begin
               if (more) begin
                  idx_q <= idx_q + 1'b1;
                  if (!noinc_q) ptr_q <= ptr_q + 1'b1;
               end else begin
                  st_q <= ST_WBC;
               end
            end
            ST_RX: begin
               if (rx_end) begin
                  hs_valid_q <= !no_hs;
                  hs_code_q  <= HS_ACK;
                  st_q       <= pid_bad ? ST_IDLE : ST_WBC;
               end else if (rx_take) begin
                  idx_q <= idx_q + 1'b1;
                  if (!noinc_q) ptr_q <= ptr_q + 1'b1;
               end
            end
            ST_WBC:  st_q <= ST_WBS;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      we_o = 1'b0;
      wa_o = ptr_q;
      wd_o = rx_data;
      if (rx_take) begin
         we_o = 1'b1;
      end else if (st_q == ST_WBC) begin
         we_o = 1'b1;
         wa_o = AW'(BD_BASE + 1);
         wd_o = fin_cnt[7:0];
      end else if (st_q == ST_WBS) begin
         we_o = 1'b1;
         wa_o = AW'(BD_BASE);
         wd_o = keep_q ? {stat_i[7:2], fin_cnt[9:8]}
                       : {2'b00, (dir_in_q ? PID_IN : PID_OUT), fin_cnt[9:8]};
      end
   end

   assign rd_idx_o = ptr_q;
   assign tx_valid = (st_q == ST_TX) && more;
   assign tx_data  = rd_data_i;
   assign tx_eop   = (st_q == ST_TX) && !more;
   assign tx_pid   = exp_pid;
   assign hs_valid = hs_valid_q;
   assign hs_code  = hs_code_q;

   // a handshake always follows a token or the end of an OUT packet
   assert_hs_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> ($past(tok_valid) || $past(rx_end)));
   // a CPU-owned descriptor never starts a transfer
   assert_cpu_owned_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && tok_valid && !stat_i[SB_OWN]) |=> (st_q == ST_IDLE));
   assert_stall_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && tok_valid && dir_en && stat_i[SB_OWN] && stat_i[SB_STALL] && !no_hs)
      |=> (hs_valid && hs_code == HS_STALL));
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RX) |-> (idx_q <= cnt_q));
   assert_fixed_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && $past(st_q) != ST_IDLE && noinc_q) |-> $stable(ptr_q));
   assert_dir_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && tok_valid && !dir_en) |=> (st_q == ST_IDLE && !hs_valid));
   assert_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(no_hs) && no_hs) |-> !hs_valid);
endmodule

// File: rtl/usb_bd_engine.sv
`timescale 1ns/1ps
module usb_bd_engine
   import usb_bd_pkg::*;
#(
   parameter int RAM_DEPTH   = 64,
   parameter int BD_BASE     = 0,
   parameter bit RESET_CLEAR = 1'b1,
   localparam int AW         = $clog2(RAM_DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_rdata,
   input  logic          ep_en_in,
   input  logic          ep_en_out,
   input  logic          ep_no_hs,
   input  logic          tok_valid,
   input  logic          tok_in,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_end,
   input  logic [3:0]    rx_pid,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_eop,
   output logic [3:0]    tx_pid,
   output logic          hs_valid,
   output logic [1:0]    hs_code
);
   initial begin
      assert (RAM_DEPTH >= 8 && (RAM_DEPTH & (RAM_DEPTH - 1)) == 0)
         else $error("RAM_DEPTH must be a power of two of at least 8");
      assert (BD_BASE >= 0 && BD_BASE + 3 < RAM_DEPTH)
         else $error("descriptor must fit inside the RAM");
   end

   logic [RAM_DEPTH-1:0][7:0] mem_q;
   logic                      eng_we;
   logic [AW-1:0]             eng_wa, rd_idx;
   logic [7:0]                eng_wd;

   usb_bd_ram #(.DEPTH(RAM_DEPTH), .RESET_CLEAR(RESET_CLEAR)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .eng_we(eng_we), .eng_addr(eng_wa), .eng_wdata(eng_wd),
      .q(mem_q)
   );

   assign cpu_rdata = mem_q[cpu_addr];

   usb_bd_sie_fsm #(.AW(AW), .BD_BASE(BD_BASE)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_in(tok_in),
      .en_in(ep_en_in), .en_out(ep_en_out), .no_hs(ep_no_hs),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_pid(rx_pid),
      .stat_i(mem_q[BD_BASE]), .cntl_i(mem_q[BD_BASE+1]),
      .adrl_i(mem_q[BD_BASE+2]), .adrh_i(mem_q[BD_BASE+3]),
      .rd_data_i(mem_q[rd_idx]), .rd_idx_o(rd_idx),
      .we_o(eng_we), .wa_o(eng_wa), .wd_o(eng_wd),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_eop(tx_eop), .tx_pid(tx_pid),
      .hs_valid(hs_valid), .hs_code(hs_code)
   );
endmodule

// File: tb/tb_usb_bd_engine.sv
`timescale 1ns/1ps
module tb_usb_bd_engine;
   localparam int D = 64;
   logic clk = 0, rst_n = 0;
   logic cpu_we = 0; logic [5:0] cpu_addr = 0; logic [7:0] cpu_wdata = 0;
   logic [7:0] cpu_rdata;
   logic en_in = 1, en_out = 1, no_hs = 0;
   logic tok_valid = 0, tok_in = 0, rx_valid = 0, rx_end = 0;
   logic [7:0] rx_data = 0; logic [3:0] rx_pid = 0;
   logic tx_valid, tx_eop, hs_valid; logic [7:0] tx_data;
   logic [3:0] tx_pid; logic [1:0] hs_code;

   usb_bd_engine dut (.clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ep_en_in(en_in), .ep_en_out(en_out),
      .ep_no_hs(no_hs), .tok_valid(tok_valid), .tok_in(tok_in), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_end(rx_end), .rx_pid(rx_pid), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_eop(tx_eop), .tx_pid(tx_pid), .hs_valid(hs_valid),
      .hs_code(hs_code));

   always #4 clk = ~clk;

   int checks = 0, fails = 0;
   string cur_req = "R1";
   logic [7:0] m [D];
   logic [7:0] exp_tx[$];
   logic [3:0] exp_eop[$];
   logic [1:0] exp_hs[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // reference monitor, sampled every negedge
   always @(negedge clk) if (rst_n) begin
      if (tx_valid) begin
         chk(exp_tx.size() > 0, cur_req, tx_data, -1);
         if (exp_tx.size() > 0) chk(tx_data == exp_tx.pop_front(), cur_req, tx_data, -2);
      end
      if (tx_eop) begin
         chk(exp_eop.size() > 0, cur_req, tx_pid, -1);
         if (exp_eop.size() > 0) begin
            logic [3:0] e; e = exp_eop.pop_front();
            chk(tx_pid == e, cur_req, tx_pid, e);
         end
      end
      if (hs_valid) begin
         chk(exp_hs.size() > 0, cur_req, hs_code, -1);
         if (exp_hs.size() > 0) begin
            logic [1:0] e; e = exp_hs.pop_front();
            chk(hs_code == e, cur_req, hs_code, e);
         end
      end
   end

   task automatic cpu_wr(input int a, input logic [7:0] d);
      @(negedge clk); cpu_we = 1; cpu_addr = 6'(a); cpu_wdata = d;
      @(negedge clk); cpu_we = 0;
      m[a] = d;
   endtask

   task automatic compare_ram(input string req);
      for (int a = 0; a < D; a++) begin
         @(negedge clk); cpu_addr = 6'(a); #1;
         chk(cpu_rdata === m[a], req, cpu_rdata, m[a]);
      end
   endtask

   task automatic leftovers(input string req);
      chk(exp_tx.size() == 0 && exp_eop.size() == 0 && exp_hs.size() == 0, req,
          exp_tx.size() + exp_eop.size() + exp_hs.size(), 0);
      exp_tx.delete(); exp_eop.delete(); exp_hs.delete();
   endtask

   task automatic set_bd(input logic [7:0] st, input int cnt, input int adr);
      cpu_wr(1, cnt[7:0]); cpu_wr(2, adr[7:0]); cpu_wr(3, adr[15:8]);
      cpu_wr(0, {st[7:2], cnt[9:8]});
   endtask

   function automatic int cnt_of(); return {m[0][1:0], m[1]}; endfunction

   function automatic void wb(input int c, input logic [3:0] pid);
      if (m[0][5]) m[0] = {m[0][7:2], c[9:8]};
      else         m[0] = {2'b00, pid, c[9:8]};
      m[1] = c[7:0];
   endfunction

   task automatic do_in(input string req);
      int c, a, n; bit go; go = 0; n = 0;
      cur_req = req;
      if (en_in) begin
         if (!m[0][7]) begin if (!no_hs) exp_hs.push_back(2'd1); end
         else if (m[0][2]) begin if (!no_hs) exp_hs.push_back(2'd2); end
         else begin
            go = 1; c = cnt_of(); n = c; a = {m[3], m[2]} % D;
            for (int i = 0; i < c; i++) begin
               exp_tx.push_back(m[a]);
               if (!m[0][4]) a = (a + 1) % D;
            end
            exp_eop.push_back(m[0][6] ? 4'b1011 : 4'b0011);
         end
      end
      @(negedge clk); tok_valid = 1; tok_in = 1;
      @(negedge clk); tok_valid = 0;
      repeat (n + 6) @(negedge clk);
      if (go) wb(n, 4'b1001);
      leftovers(req);
      compare_ram(req);
   endtask

   task automatic do_out(input int nb, input int first, input logic [3:0] pid, input string req);
      int c, a, r; bit go; go = 0; r = 0;
      cur_req = req;
      if (en_out) begin
         if (!m[0][7]) begin if (!no_hs) exp_hs.push_back(2'd1); end
         else if (m[0][2]) begin if (!no_hs) exp_hs.push_back(2'd2); end
         else begin
            go = 1; c = cnt_of(); a = {m[3], m[2]} % D;
            if (!no_hs) exp_hs.push_back(2'd0);
         end
      end
      @(negedge clk); tok_valid = 1; tok_in = 0;
      @(negedge clk); tok_valid = 0;
      if (go) begin
         for (int k = 0; k < nb; k++) begin
            rx_valid = 1; rx_data = 8'(first + k);
            if (r < c) begin
               m[a] = 8'(first + k); r++;
               if (!m[0][4]) a = (a + 1) % D;
            end
            @(negedge clk);
         end
         rx_valid = 0; rx_end = 1; rx_pid = pid;
         @(negedge clk); rx_end = 0;
         if (!(m[0][3] && pid != (m[0][6] ? 4'b1011 : 4'b0011))) wb(r, 4'b0001);
      end
      repeat (5) @(negedge clk);
      leftovers(req);
      compare_ram(req);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int a = 0; a < D; a++) m[a] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(!hs_valid && !tx_valid && !tx_eop, "R1", {hs_valid, tx_valid, tx_eop}, 0);
      compare_ram("R1");
      for (int a = 16; a < 48; a++) cpu_wr(a, 8'(a * 7 + 3));
      // R3: CPU owns, NAK and no change
      set_bd(8'h00, 5, 16); do_in("R3");
      // R4: stall
      set_bd(8'h84, 5, 16); do_in("R4"); do_out(2, 8'h50, 4'b0011, "R4");
      // R5/R7: IN with DATA0, release
      set_bd(8'h80, 5, 16); do_in("R5_R7");
      // R5: DATA1
      set_bd(8'hC0, 3, 20); do_in("R5");
      // R2: 10-bit count and address wrap over the RAM
      set_bd(8'h80, 258, 16'h0130); do_in("R2");
      // R6/R7: OUT longer than count, then shorter
      set_bd(8'h80, 4, 32); do_out(6, 8'hA0, 4'b0011, "R6_R7");
      set_bd(8'h80, 8, 40); do_out(2, 8'hB0, 4'b1011, "R6");
      // R9: toggle sync mismatch then match
      set_bd(8'hC8, 4, 24); do_out(3, 8'hC0, 4'b0011, "R9");
      do_out(3, 8'hD0, 4'b1011, "R9");
      // R8: keep retains ownership, second transaction works
      set_bd(8'hA0, 2, 16); do_in("R8"); do_in("R8");
      set_bd(8'hA0, 3, 44); do_out(2, 8'hE0, 4'b0011, "R8");
      // R10: no increment
      set_bd(8'h90, 3, 18); do_in("R10");
      set_bd(8'h90, 4, 30); do_out(4, 8'h60, 4'b0011, "R10");
      // R11: direction disabled
      en_in = 0; set_bd(8'h80, 1, 16); do_in("R11"); en_in = 1;
      en_out = 0; do_out(2, 8'h70, 4'b0011, "R11"); en_out = 1;
      // R12: handshakes suppressed
      no_hs = 1;
      set_bd(8'h80, 2, 36); do_out(2, 8'h11, 4'b0011, "R12");
      set_bd(8'h00, 2, 36); do_in("R12");
      no_hs = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule